// File: doc/BRIEF.md
# Periodic ADC Conversion Trigger and Serial Read Sequencer

This block sits on the host side of an 18-bit successive-approximation converter. A free-running interval timer starts a conversion at a fixed rate with a short convert pulse. The sequencer then waits for the converter to report the end of conversion, which it does by dropping its busy line.

On that falling edge the sequencer runs a 24-clock, three-byte serial read as the bus master. The serial clock idles low, and received data is captured on the falling clock edge (CPOL 0, CPHA 1). The first 18 bits received form the sample, most significant bit first. The 6 padding bits that follow are thrown away. The finished sample is presented together with a one-cycle valid strobe.

If the timer fires while a conversion or a read is still open, the tick is dropped and a sticky overrun flag is raised. The serial clock divider is fixed by a parameter. An elaboration-time check rejects any divider that would drive the serial clock above 17 MHz.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `cnv_o` goes high for exactly CNV_CYCLES clock cycles on each accepted timer tick, and accepted ticks are TICK_PERIOD clock cycles apart.
- R2: A read starts only on a falling edge of `busy_i` seen after a convert pulse. `cs_n_o` falls SYNC_STAGES+2 cycles after `busy_i` falls. Edges of `busy_i` at any other time cause no serial activity.
- R3: During a read `cs_n_o` is low and `sck_o` makes exactly 24 rising edges. The first rising edge comes SCK_HALF cycles after `cs_n_o` falls. `sck_o` is low whenever `cs_n_o` is high.
- R4: `miso_i` is captured on each falling `sck_o` edge. The sample equals the first 18 captured bits, with the first bit in `sample_o[17]`. The last 6 captured bits do not affect `sample_o`.
- R5: `sample_vld_o` is high for one cycle only, in the cycle after `cs_n_o` rises. `sample_o` changes only together with `sample_vld_o`.
- R6: A timer tick that arrives while a conversion or read is open starts no conversion, so the next convert pulse comes 2*TICK_PERIOD after the previous one. The tick sets `overrun_o`, which then stays high until reset.
- R7: Each `sck_o` level lasts SCK_HALF cycles. The build is rejected at elaboration when CLK_HZ/(2*SCK_HALF) exceeds 17 MHz.
- R8: After reset `cnv_o`, `sck_o`, `sample_vld_o`, `overrun_o` and `sample_o` are 0, and `cs_n_o` is 1.
- R9: `cnv_o` is never high while `cs_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_i | input | 1 | Converter busy, asynchronous; falling edge ends a conversion |
| miso_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert start pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| sample_o | output | 18 | Most recent sample |
| sample_vld_o | output | 1 | One-cycle strobe when `sample_o` updates |
| overrun_o | output | 1 | Sticky flag for a dropped timer tick |

## Verification
The bench builds the block with CLK_HZ = 100 MHz and SCK_HALF = 3, which puts the serial clock at 16.7 MHz, just under the ceiling. It also uses TICK_PERIOD = 300 and CNV_CYCLES = 3. With these values a normal conversion and read end well inside one tick interval, so the exact spacing of convert pulses can be checked. A converter model that stretches busy past one interval forces a tick to arrive during an open conversion, which exercises the drop and the overrun flag. The model appends a fixed non-zero padding pattern after each 18-bit word, so that any leak of the discarded bits into the sample would be caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CONV, SQ_WAIT, SQ_READ} seq_state_t;
  typedef enum logic [1:0] {SP_IDLE, SP_LEAD, SP_SHIFT, SP_TRAIL} spi_state_t;
  localparam longint unsigned SCK_LIMIT_HZ = 64'd17_000_000;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int PERIOD = 300
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= '0;
      prev   <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync   <= {sync[STAGES-2:0], d_i};
      prev   <= sync[STAGES-1];
      fall_o <= prev & ~sync[STAGES-1];
    end
  end
endmodule

// File: rtl/adc_spi_rx.sv
module adc_spi_rx
  import adc_seq_pkg::*;
#(
  parameter int HALF = 3,
  parameter int BITS = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            miso_i,
  output logic            cs_n_o,
  output logic            sck_o,
  output logic            done_o,
  output logic [BITS-1:0] word_o
);
  localparam int HW = $clog2(HALF) + 1;
  localparam int BW = $clog2(BITS + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BITS - 1);

  spi_state_t    st;
  logic [HW-1:0] hc;
  logic [BW-1:0] bc;
  logic [BITS-1:0] shreg;

  assign word_o = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SP_IDLE;
      hc     <= '0;
      bc     <= '0;
      shreg  <= '0;
      cs_n_o <= 1'b1;
      sck_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        SP_IDLE: begin
          if (start_i) begin
            st     <= SP_LEAD;
            cs_n_o <= 1'b0;
            hc     <= '0;
            bc     <= '0;
          end
        end
        SP_LEAD: begin
          if (hc == H_LAST) begin
            hc    <= '0;
            sck_o <= 1'b1;
            st    <= SP_SHIFT;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        SP_SHIFT: begin
          if (hc == H_LAST) begin
            hc <= '0;
            if (sck_o) begin
              sck_o <= 1'b0;
              shreg <= {shreg[BITS-2:0], miso_i};
              if (bc == B_LAST) begin
                bc <= '0;
                st <= SP_TRAIL;
              end else begin
                bc <= bc + 1'b1;
              end
            end else begin
              sck_o <= 1'b1;
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
        SP_TRAIL: begin
          if (hc == H_LAST) begin
            hc     <= '0;
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
            st     <= SP_IDLE;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: st <= SP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd100_000_000,
  parameter int SCK_HALF    = 3,
  parameter int TICK_PERIOD = 300,
  parameter int CNV_CYCLES  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_W    = 18,
  parameter int XFER_BYTES  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy_i,
  input  logic                miso_i,
  output logic                cnv_o,
  output logic                cs_n_o,
  output logic                sck_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld_o,
  output logic                overrun_o
);
  localparam int XFER_BITS = 8 * XFER_BYTES;
  localparam int CCW = $clog2(CNV_CYCLES + 1);
  localparam logic [CCW-1:0] CNV_LAST = CCW'(CNV_CYCLES - 1);

  // R7: serial clock ceiling enforced while the design is elaborated
  if (CLK_HZ > SCK_LIMIT_HZ * 64'(2 * SCK_HALF)) begin : g_sck_too_fast
    $error("serial clock divider gives more than 17 MHz");
  end
  if (SAMPLE_W > XFER_BITS) begin : g_sample_too_wide
    $error("sample wider than transfer");
  end

  logic tick;
  logic busy_fall;
  logic spi_start;
  logic spi_done;
  logic [XFER_BITS-1:0] spi_word;

  seq_state_t     st;
  logic [CCW-1:0] cc;

  adc_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_busy (
    .clk(clk), .rst(rst), .d_i(busy_i), .fall_o(busy_fall)
  );

  assign spi_start = (st == SQ_WAIT) && busy_fall;

  adc_spi_rx #(.HALF(SCK_HALF), .BITS(XFER_BITS)) u_spi (
    .clk(clk), .rst(rst), .start_i(spi_start), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .done_o(spi_done), .word_o(spi_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SQ_IDLE;
      cc           <= '0;
      cnv_o        <= 1'b0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
      overrun_o    <= 1'b0;
    end else begin
      sample_vld_o <= 1'b0;
      if (tick && st != SQ_IDLE) overrun_o <= 1'b1;
      case (st)
        SQ_IDLE: begin
          if (tick) begin
            cnv_o <= 1'b1;
            cc    <= '0;
            st    <= SQ_CONV;
          end
        end
        SQ_CONV: begin
          if (cc == CNV_LAST) begin
            cnv_o <= 1'b0;
            st    <= SQ_WAIT;
          end else begin
            cc <= cc + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (busy_fall) st <= SQ_READ;
        end
        SQ_READ: begin
          if (spi_done) begin
            sample_o     <= spi_word[XFER_BITS-1 -: SAMPLE_W];
            sample_vld_o <= 1'b1;
            st           <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int SAMPLE_W = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                cnv_o,
  input logic                cs_n_o,
  input logic                sck_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                sample_vld_o,
  input logic                overrun_o
);
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o);
  p_vld_single_r5: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |=> !sample_vld_o);
  p_vld_after_cs_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |=> sample_vld_o);
  p_sample_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sample_vld_o |-> $stable(sample_o));
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);
  p_no_cnv_in_read_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> !cnv_o);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
  .sample_o(sample_o), .sample_vld_o(sample_vld_o), .overrun_o(overrun_o)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int H    = 3;
  localparam int TP   = 300;
  localparam int CNVC = 3;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy = 1'b0;
  logic miso = 1'b0;
  logic cnv, cs_n, sck, vld, ovr;
  logic [17:0] sample;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int busy_fall_cyc = 0;
  int last_cnv_cyc = -1;
  int got = 0;
  bit finished = 0;
  logic [23:0] tx_word = '0;
  logic [17:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl #(
    .CLK_HZ(64'd100_000_000), .SCK_HALF(H), .TICK_PERIOD(TP),
    .CNV_CYCLES(CNVC), .SYNC_STAGES(SYNC), .SAMPLE_W(18), .XFER_BYTES(3)
  ) u0 (
    .clk(clk), .rst(rst), .busy_i(busy), .miso_i(miso), .cnv_o(cnv),
    .cs_n_o(cs_n), .sck_o(sck), .sample_o(sample), .sample_vld_o(vld),
    .overrun_o(ovr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: launches one bit per rising serial clock edge
  initial begin
    int idx = 0;
    forever begin
      @(posedge sck or posedge cs_n);
      if (cs_n) idx = 0;
      else begin
        #1;
        miso = tx_word[23 - idx];
        idx++;
      end
    end
  end

  // driver: one conversion with given result and busy length
  task automatic do_conv(input logic [17:0] val, input int blen, input int exp_gap);
    @(posedge cnv);
    @(negedge clk);
    if (exp_gap > 0)
      check(cyc - last_cnv_cyc == exp_gap, "R1/R6 convert spacing", cyc - last_cnv_cyc, exp_gap);
    last_cnv_cyc = cyc;
    tx_word = {val, 6'b101101};
    exp_q.push_back(val);
    @(negedge clk);
    busy = 1'b1;
    repeat (blen) @(negedge clk);
    busy = 1'b0;
    busy_fall_cyc = cyc;
  endtask

  // monitor: scoreboard and frame checks
  initial begin
    bit pcs = 1, psck = 0, pvld = 0, pcnv = 0;
    int rises = 0, csfall = 0, lastrise = 0, cnvw = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (vld) begin
          if (exp_q.size() == 0) check(0, "R4 unexpected sample", int'(sample), -1);
          else begin
            logic [17:0] e;
            e = exp_q.pop_front();
            check(sample == e, "R4 sample value", int'(sample), int'(e));
          end
          check(cs_n == 1'b1, "R5 chip select released at valid", int'(cs_n), 1);
          got++;
        end
        if (vld && pvld) check(0, "R5 valid longer than one cycle", 2, 1);
        if (cnv) cnvw++;
        if (!cnv && pcnv) begin
          check(cnvw == CNVC, "R1 convert width", cnvw, CNVC);
          cnvw = 0;
        end
        if (!cs_n && pcs) begin
          rises = 0;
          csfall = cyc;
          check(cyc - busy_fall_cyc == SYNC + 2, "R2 read latency after busy fall",
                cyc - busy_fall_cyc, SYNC + 2);
        end
        if (sck && !psck) begin
          if (rises == 0)
            check(cyc - csfall == H, "R3 lead before first edge", cyc - csfall, H);
          else if (rises == 1)
            check(cyc - lastrise == 2 * H, "R7 serial clock period", cyc - lastrise, 2 * H);
          rises++;
          lastrise = cyc;
        end
        if (cs_n && !pcs)
          check(rises == 24, "R3 serial edges per read", rises, 24);
        if (cnv && !cs_n) check(0, "R9 convert during read", 1, 0);
        pcs = cs_n; psck = sck; pvld = vld; pcnv = cnv;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset state
    check(cnv == 0 && sck == 0 && vld == 0 && ovr == 0 && sample == 0,
          "R8 reset outputs low", int'({cnv, sck, vld, ovr}), 0);
    check(cs_n == 1, "R8 chip select idle high", int'(cs_n), 1);
    rst = 1'b0;

    do_conv(18'h3FFFF, 40, 0);
    do_conv(18'h00000, 40, TP);
    do_conv(18'h2AAAA, 40, TP);
    wait (got == 3);
    // R2: busy edges while idle start no read
    @(negedge clk);
    busy = 1'b1;
    repeat (5) @(negedge clk);
    busy = 1'b0;
    begin
      int lows = 0;
      repeat (25) begin
        @(negedge clk);
        if (!cs_n || vld) lows++;
      end
      check(lows == 0, "R2 stray busy edge ignored", lows, 0);
    end
    do_conv(18'h15555, 40, TP);
    do_conv(18'h20001, 45, TP);
    do_conv(18'h1FFFE, 35, TP);
    wait (got == 6);
    check(ovr == 0, "R6 no overrun yet", int'(ovr), 0);
    // R6: long conversion swallows one tick
    do_conv(18'h3C00F, 350, TP);
    wait (got == 7);
    check(ovr == 1, "R6 overrun set", int'(ovr), 1);
    do_conv(18'h0F0F0, 40, 2 * TP);
    wait (got == 8);
    check(ovr == 1, "R6 overrun sticky", int'(ovr), 1);
    check(exp_q.size() == 0, "R4 all samples delivered", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", got, 8);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule